// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Load-Store Core

This block is a small 64-bit processor that finishes one instruction on every rising clock edge. It recognises four instructions. The first adds two registers. The second loads a doubleword from memory into a register, and the third stores a register to memory. The fourth moves the program counter by a signed word offset when a register holds zero. The core keeps 32 registers, a program counter, a word-addressed instruction store and a doubleword data store, all inside the block.

A test environment fills the instruction store, the data store and the registers through dedicated load ports while reset is held. It then releases reset and lets the program run for a chosen number of clocks. After that it reasserts reset and reads the registers and the data store back through peek ports. Any instruction word that matches none of the four encodings only advances the program counter.

Top module: `lsr_core`

## Requirements
- R1: While `rst` is high the program counter reads 0 and no instruction changes a register or the data store; the first instruction after reset is fetched from byte address 0.
- R2: A word whose bits [31:21] are 10001011000 adds the register named by bits [9:5] to the register named by bits [20:16] and writes the 64-bit sum, wrapping modulo 2^64, to the register named by bits [4:0]; bits [15:10] have no effect.
- R3: A word whose bits [31:21] are 11111000010 writes to register bits [4:0] the doubleword at byte address (register bits [9:5]) + zero-extended bits [20:12].
- R4: A word whose bits [31:21] are 11111000000 writes register bits [4:0] to the doubleword at byte address (register bits [9:5]) + zero-extended bits [20:12].
- R5: A word whose bits [31:24] are 10110100, when the register named by bits [4:0] is zero, sets the next program counter to its own address plus four times the sign-extended 19-bit field in bits [23:5], so negative values branch backward.
- R6: The same compare-and-branch word, when its register is non-zero, advances the program counter by 4.
- R7: Every instruction other than a taken branch advances the program counter by 4, and a word that matches none of the four encodings changes no register and no memory.
- R8: Register 31 always reads as zero, and writes to it are dropped.
- R9: Data addresses select a doubleword by address bits [3+] and ignore address bits [2:0].
- R10: The instruction, data and register load ports take effect only while `rst` is high, and the peek ports read the data store and registers at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the load ports |
| imem_ld_en | input | 1 | Write strobe for the instruction store |
| imem_ld_idx | input | $clog2(IMEM_WORDS) | Instruction word index |
| imem_ld_word | input | 32 | Instruction word to store |
| dmem_ld_en | input | 1 | Write strobe for the data store |
| dmem_ld_idx | input | $clog2(DMEM_WORDS) | Doubleword index for loading |
| dmem_ld_data | input | 64 | Doubleword to store |
| dmem_pk_idx | input | $clog2(DMEM_WORDS) | Doubleword index to read back |
| dmem_pk_data | output | 64 | Doubleword at `dmem_pk_idx` |
| reg_ld_en | input | 1 | Write strobe for the registers |
| reg_ld_idx | input | 5 | Register to load |
| reg_ld_data | input | 64 | Value to load |
| reg_pk_idx | input | 5 | Register to read back |
| reg_pk_data | output | 64 | Value of register `reg_pk_idx` |
| pc_o | output | 64 | Current program counter |

## Verification
Register, data-store and program-counter results all land on the first rising edge after an instruction is fetched. After a run of N edges, exactly the first N instructions on the executed path have taken effect. The bench changes inputs and samples outputs only on falling edges. It releases reset, waits a fixed number of falling edges, and checks the program counter there. It then reasserts reset, so that the stored state is frozen before the peek ports read it. For branch sequences it samples the program counter on every falling edge, one instruction per sample.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int XLEN     = 64;
    localparam int ILEN     = 32;
    localparam int NREGS    = 32;
    localparam int RIDX_W   = $clog2(NREGS);
    localparam int ZERO_REG = NREGS - 1;
    localparam int DOFF_W   = 9;
    localparam int BOFF_W   = 19;

    localparam logic [10:0] OPC_ADD = 11'b10001011000;
    localparam logic [10:0] OPC_LDR = 11'b11111000010;
    localparam logic [10:0] OPC_STR = 11'b11111000000;
    localparam logic [7:0]  OPC_CBZ = 8'b10110100;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ADD,
        OP_LDR,
        OP_STR,
        OP_CBZ
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [RIDX_W-1:0]  dst;
        logic [RIDX_W-1:0]  src_a;
        logic [RIDX_W-1:0]  src_b;
        logic [DOFF_W-1:0]  d_off;
        logic [BOFF_W-1:0]  b_off;
        logic               reg_wr;
        logic               mem_wr;
    } ctrl_t;

    function automatic logic [XLEN-1:0] branch_target(
        input logic [XLEN-1:0]   pc,
        input logic [BOFF_W-1:0] off
    );
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-BOFF_W){off[BOFF_W-1]}}, off};
        return pc + (ext << 2);
    endfunction

    function automatic logic [XLEN-1:0] data_addr(
        input logic [XLEN-1:0]   base,
        input logic [DOFF_W-1:0] off
    );
        return base + {{(XLEN-DOFF_W){1'b0}}, off};
    endfunction

endpackage

// File: rtl/lsr_decoder.sv
module lsr_decoder
    import lsr_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic unused_fields;
    assign unused_fields = ^{instr[15:10]};

    op_e op;

    always_comb begin
        if (instr[31:21] == OPC_ADD)      op = OP_ADD;
        else if (instr[31:21] == OPC_LDR) op = OP_LDR;
        else if (instr[31:21] == OPC_STR) op = OP_STR;
        else if (instr[31:24] == OPC_CBZ) op = OP_CBZ;
        else                              op = OP_NOP;
    end

    always_comb begin
        ctrl        = '0;
        ctrl.op     = op;
        ctrl.dst    = instr[4:0];
        ctrl.src_a  = instr[9:5];
        ctrl.src_b  = (op == OP_ADD) ? instr[20:16] : instr[4:0];
        ctrl.d_off  = instr[20:12];
        ctrl.b_off  = instr[23:5];
        ctrl.reg_wr = (op == OP_ADD) || (op == OP_LDR);
        ctrl.mem_wr = (op == OP_STR);
    end
endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile
    import lsr_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    output logic [XLEN-1:0]   rdata_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_b,
    input  logic [RIDX_W-1:0] raddr_p,
    output logic [XLEN-1:0]   rdata_p
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && (waddr != RIDX_W'(ZERO_REG)))
            regs[waddr] <= wdata;
    end

    function automatic logic [XLEN-1:0] rd_port(input logic [RIDX_W-1:0] a,
                                                input logic [XLEN-1:0]   v);
        return (a == RIDX_W'(ZERO_REG)) ? '0 : v;
    endfunction

    assign rdata_a = rd_port(raddr_a, regs[raddr_a]);
    assign rdata_b = rd_port(raddr_b, regs[raddr_b]);
    assign rdata_p = rd_port(raddr_p, regs[raddr_p]);
endmodule

// File: rtl/lsr_imem.sv
module lsr_imem
    import lsr_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [ILEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [ILEN-1:0] rdata
);
    logic [ILEN-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            words[waddr] <= wdata;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/lsr_dmem.sv
module lsr_dmem
    import lsr_pkg::*;
#(
    parameter int WORDS = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    input  logic [AW-1:0]   paddr,
    output logic [XLEN-1:0] pdata
);
    logic [XLEN-1:0] dwords [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            dwords[waddr] <= wdata;
    end

    assign rdata = dwords[raddr];
    assign pdata = dwords[paddr];
endmodule

// File: rtl/lsr_core.sv
module lsr_core
    import lsr_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 32,
    localparam int IA_W      = $clog2(IMEM_WORDS),
    localparam int DA_W      = $clog2(DMEM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  imem_ld_en,
    input  logic [IA_W-1:0]       imem_ld_idx,
    input  logic [ILEN-1:0]       imem_ld_word,
    input  logic                  dmem_ld_en,
    input  logic [DA_W-1:0]       dmem_ld_idx,
    input  logic [XLEN-1:0]       dmem_ld_data,
    input  logic [DA_W-1:0]       dmem_pk_idx,
    output logic [XLEN-1:0]       dmem_pk_data,
    input  logic                  reg_ld_en,
    input  logic [RIDX_W-1:0]     reg_ld_idx,
    input  logic [XLEN-1:0]       reg_ld_data,
    input  logic [RIDX_W-1:0]     reg_pk_idx,
    output logic [XLEN-1:0]       reg_pk_data,
    output logic [XLEN-1:0]       pc_o
);
    logic [XLEN-1:0] pc_q, pc_next;
    logic [ILEN-1:0] instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] src_a_val, src_b_val;
    logic [XLEN-1:0] mem_addr, mem_rdata, sum;
    logic [DA_W-1:0] mem_idx;
    logic            branch_taken;

    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic              dm_we;
    logic [DA_W-1:0]   dm_waddr;
    logic [XLEN-1:0]   dm_wdata;

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IA_W+2],
                           mem_addr[2:0], mem_addr[XLEN-1:DA_W+3]};

    // Fetch
    lsr_imem #(.WORDS(IMEM_WORDS)) imem_i (
        .clk   (clk),
        .we    (rst && imem_ld_en),
        .waddr (imem_ld_idx),
        .wdata (imem_ld_word),
        .raddr (pc_q[IA_W+1:2]),
        .rdata (instr)
    );

    lsr_decoder dec_i (
        .instr (instr),
        .ctrl  (ctrl)
    );

    // Register file: load port while in reset, core write port otherwise
    always_comb begin
        if (rst) begin
            rf_we    = reg_ld_en;
            rf_waddr = reg_ld_idx;
            rf_wdata = reg_ld_data;
        end else begin
            rf_we    = ctrl.reg_wr;
            rf_waddr = ctrl.dst;
            rf_wdata = (ctrl.op == OP_LDR) ? mem_rdata : sum;
        end
    end

    lsr_regfile rf_i (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ctrl.src_a),
        .rdata_a (src_a_val),
        .raddr_b (ctrl.src_b),
        .rdata_b (src_b_val),
        .raddr_p (reg_pk_idx),
        .rdata_p (reg_pk_data)
    );

    // Execute
    assign sum      = src_a_val + src_b_val;
    assign mem_addr = data_addr(src_a_val, ctrl.d_off);
    assign mem_idx  = mem_addr[DA_W+2:3];

    always_comb begin
        if (rst) begin
            dm_we    = dmem_ld_en;
            dm_waddr = dmem_ld_idx;
            dm_wdata = dmem_ld_data;
        end else begin
            dm_we    = ctrl.mem_wr;
            dm_waddr = mem_idx;
            dm_wdata = src_b_val;
        end
    end

    lsr_dmem #(.WORDS(DMEM_WORDS)) dmem_i (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (mem_idx),
        .rdata (mem_rdata),
        .paddr (dmem_pk_idx),
        .pdata (dmem_pk_data)
    );

    // Program counter
    assign branch_taken = (ctrl.op == OP_CBZ) && (src_b_val == '0);
    assign pc_next      = branch_taken ? branch_target(pc_q, ctrl.b_off)
                                       : pc_q + XLEN'(4);

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/lsr_core_chk.sv
module lsr_core_chk
    import lsr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [ILEN-1:0] instr,
    input logic [XLEN-1:0] ra_val,
    input logic [XLEN-1:0] rb_val
);
    logic is_cbz;
    logic [XLEN-1:0] off_bytes;
    assign is_cbz    = (instr[31:24] == OPC_CBZ);
    assign off_bytes = {{(XLEN-BOFF_W-2){instr[23]}}, instr[23:5], 2'b00};

    AST_PC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc == '0);                                        // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !is_cbz |=> pc == $past(pc) + XLEN'(4));                         // R7

    AST_CBZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (is_cbz && rb_val == '0) |=> pc == $past(pc) + $past(off_bytes)); // R5

    AST_CBZ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (is_cbz && rb_val != '0) |=> pc == $past(pc) + XLEN'(4));        // R6

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
        (instr[9:5] == 5'd31) |-> ra_val == '0);                         // R8
endmodule

bind lsr_core lsr_core_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_q),
    .instr  (instr),
    .ra_val (src_a_val),
    .rb_val (src_b_val)
);

// File: tb/lsr_core_tb.sv
module lsr_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 64;
    localparam int DW = 32;
    localparam int IA = $clog2(IW);
    localparam int DA = $clog2(DW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic          imem_ld_en = 0;
    logic [IA-1:0] imem_ld_idx = '0;
    logic [31:0]   imem_ld_word = '0;
    logic          dmem_ld_en = 0;
    logic [DA-1:0] dmem_ld_idx = '0;
    logic [63:0]   dmem_ld_data = '0;
    logic [DA-1:0] dmem_pk_idx = '0;
    logic [63:0]   dmem_pk_data;
    logic          reg_ld_en = 0;
    logic [4:0]    reg_ld_idx = '0;
    logic [63:0]   reg_ld_data = '0;
    logic [4:0]    reg_pk_idx = '0;
    logic [63:0]   reg_pk_data;
    logic [63:0]   pc_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsr_core dut_i (.*);

    function automatic logic [31:0] e_add(input int rd, input int rn, input int rm, input int sh);
        return {11'b10001011000, 5'(rm), 6'(sh), 5'(rn), 5'(rd)};
    endfunction
    function automatic logic [31:0] e_ldr(input int rt, input int rn, input int off);
        return {11'b11111000010, 9'(off), 2'b00, 5'(rn), 5'(rt)};
    endfunction
    function automatic logic [31:0] e_str(input int rt, input int rn, input int off);
        return {11'b11111000000, 9'(off), 2'b00, 5'(rn), 5'(rt)};
    endfunction
    function automatic logic [31:0] e_cbz(input int rt, input int off);
        return {8'b10110100, 19'(off), 5'(rt)};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put_instr(input int idx, input logic [31:0] w);
        @(negedge clk);
        imem_ld_en = 1; imem_ld_idx = IA'(idx); imem_ld_word = w;
        @(negedge clk);
        imem_ld_en = 0;
    endtask

    task automatic put_data(input int idx, input logic [63:0] d);
        @(negedge clk);
        dmem_ld_en = 1; dmem_ld_idx = DA'(idx); dmem_ld_data = d;
        @(negedge clk);
        dmem_ld_en = 0;
    endtask

    task automatic put_reg(input int idx, input logic [63:0] d);
        @(negedge clk);
        reg_ld_en = 1; reg_ld_idx = 5'(idx); reg_ld_data = d;
        @(negedge clk);
        reg_ld_en = 0;
    endtask

    task automatic get_reg(input int idx, output logic [63:0] v);
        reg_pk_idx = 5'(idx);
        #1 v = reg_pk_data;
    endtask

    task automatic get_data(input int idx, output logic [63:0] v);
        dmem_pk_idx = DA'(idx);
        #1 v = dmem_pk_data;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
    endtask

    task automatic clear_program();
        for (int i = 0; i < IW; i++) put_instr(i, 32'h0);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        clear_program();
        put_reg(1, 64'd21);
        put_reg(14, 64'd0);
        put_instr(0, e_add(14, 1, 1, 0));
        repeat (5) @(negedge clk);
        check("R1 pc held at 0 in reset", pc_o, 64'd0);
        get_reg(14, v);
        check("R1 no register write in reset", v, 64'd0);
        run(1);
        check("R1 first fetch from address 0, pc", pc_o, 64'd4);
        enter_reset();
        get_reg(14, v);
        check("R1 first instruction executed", v, 64'd42);
    endtask

    task automatic t_add();
        logic [63:0] v;
        clear_program();
        put_reg(1, 64'd5);
        put_reg(2, 64'd7);
        put_reg(11, 64'hFFFF_FFFF_FFFF_FFFF);
        put_reg(12, 64'd2);
        put_instr(0, e_add(3, 1, 2, 6'h2A));
        put_instr(1, e_add(3, 3, 3, 0));
        put_instr(2, e_add(13, 11, 12, 6'h3F));
        run(3);
        check("R7 pc after three adds", pc_o, 64'd12);
        enter_reset();
        get_reg(3, v);
        check("R2 add chain", v, 64'd24);
        get_reg(13, v);
        check("R2 add wraps", v, 64'd1);
    endtask

    task automatic t_ldst();
        logic [63:0] v;
        clear_program();
        put_reg(1, 64'd8);
        put_data(2, 64'hDEAD_BEEF_0123_4567);
        put_data(3, 64'h0);
        put_data(31, 64'h77);
        put_instr(0, e_ldr(4, 1, 8));
        put_instr(1, e_str(4, 1, 16));
        put_instr(2, e_ldr(5, 1, 13));
        put_instr(3, e_ldr(6, 31, 248));
        run(4);
        check("R7 pc after loads and store", pc_o, 64'd16);
        enter_reset();
        get_reg(4, v);
        check("R3 load base+offset", v, 64'hDEAD_BEEF_0123_4567);
        get_data(3, v);
        check("R4 store base+offset", v, 64'hDEAD_BEEF_0123_4567);
        get_reg(5, v);
        check("R9 low address bits ignored", v, 64'hDEAD_BEEF_0123_4567);
        get_reg(6, v);
        check("R3 large offset from zero register", v, 64'h77);
    endtask

    task automatic t_branch();
        clear_program();
        put_reg(5, 64'd0);
        put_reg(6, 64'd1);
        put_reg(7, 64'd0);
        put_instr(0, e_cbz(5, 3));
        put_instr(3, e_cbz(6, -2));
        put_instr(4, e_cbz(7, -4));
        run(1);
        check("R5 forward branch taken", pc_o, 64'd12);
        @(negedge clk);
        check("R6 branch not taken", pc_o, 64'd16);
        @(negedge clk);
        check("R5 backward branch taken", pc_o, 64'd0);
        @(negedge clk);
        check("R5 loop repeats", pc_o, 64'd12);
        enter_reset();
    endtask

    task automatic t_zero_reg();
        logic [63:0] v;
        clear_program();
        put_reg(1, 64'd5);
        put_reg(31, 64'd99);
        put_instr(0, e_add(31, 1, 1, 0));
        put_instr(1, e_add(8, 31, 1, 0));
        put_instr(2, e_cbz(31, 10));
        run(3);
        check("R8 branch on zero register taken", pc_o, 64'd48);
        enter_reset();
        get_reg(31, v);
        check("R8 zero register reads zero", v, 64'd0);
        get_reg(8, v);
        check("R8 zero register as operand", v, 64'd5);
    endtask

    task automatic t_nop();
        logic [63:0] v;
        clear_program();
        put_reg(9, 64'h55);
        put_data(0, 64'hABCD);
        put_instr(0, 32'h0000_0009);
        put_instr(1, 32'hFFFF_FFE9);
        run(2);
        check("R7 unknown opcodes advance pc", pc_o, 64'd8);
        enter_reset();
        get_reg(9, v);
        check("R7 unknown opcode leaves register", v, 64'h55);
        get_data(0, v);
        check("R7 unknown opcode leaves memory", v, 64'hABCD);
    endtask

    task automatic t_load_ports_gated();
        logic [63:0] v;
        clear_program();
        put_reg(10, 64'd3);
        put_data(4, 64'd4);
        run(1);
        reg_ld_en = 1; reg_ld_idx = 5'd10; reg_ld_data = 64'd99;
        dmem_ld_en = 1; dmem_ld_idx = DA'(4); dmem_ld_data = 64'd98;
        @(negedge clk);
        @(negedge clk);
        reg_ld_en = 0; dmem_ld_en = 0;
        get_data(4, v);
        check("R10 data peek while running", v, 64'd4);
        enter_reset();
        get_reg(10, v);
        check("R10 register load ignored when running", v, 64'd3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_add();
        t_ldst();
        t_branch();
        t_zero_reg();
        t_nop();
        t_load_ports_gated();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule